// File: doc/BRIEF.md
# Core Module System Control Register Bank

This block is the system control register bank of a processor core module. It sits on a simple 32-bit bus with a word address, a select, a write enable and a read path. A read returns data in the same cycle. A write takes effect at the next rising clock edge. The bank returns a fixed identity word and a fixed status word. It holds the main and auxiliary oscillator settings behind a 16-bit unlock key. It also holds the memory configuration and init words, two flag registers that are written through separate set and clear addresses, and a small interrupt section with one software-driven source and separate enable masks for the normal and fast interrupt lines.

A control word drives three board-level signals. One selects what appears at address zero, either the boot flash or RAM. One requests a board reset. One lights a status LED. An access to a word that the bank does not decode returns zero and changes nothing. The error output then goes high for one cycle, so a bus fabric can flag the bad access.

Top module: `cm_sysctl`

## Requirements
- R1: Word 0 reads 0x411A3001 and word 4 reads 0x00100000. Word 1, words 32 to 35 and words 64 to 127 read zero. Words 32 to 35 accept and ignore writes. None of these reads raises the error output.
- R2: After reset the registers hold these values: main oscillator (word 2) 0x01000048, auxiliary oscillator (word 7) 0x0007FEFF, init (word 9) 0x00000112, control (word 3) zero, flags zero and interrupt state zero. The memory configuration word (word 8) resets to 0x00011122 ORed with a size code, which is 0x10, 0x0C, 0x08 or 0x04 for at least 256, 128, 64 or 32 MB and zero otherwise. The default is 128 MB, giving 0x0001112E.
- R3: A write to word 5 (lock) stores only data bits 15:0. A read of word 5 returns 0x1A05F while the stored value is 0xA05F, and returns the stored value zero-extended otherwise.
- R4: Writes to words 2 and 7 update the register only while the lock holds 0xA05F. At any other time they leave it unchanged, without an error.
- R5: Writing word 12 ORs the data into the volatile flags, writing word 13 clears the bits set in the data, and word 12 reads the flags. Words 14, 15 and 14 do the same for the non-volatile flags.
- R6: Writing word 18 ORs the data into the normal interrupt enable, and writing word 19 clears the bits set in the data. Word 18 reads the enable, word 16 reads the level ANDed with the enable, and word 17 reads the raw level. The irq_o output is high whenever the level ANDed with the enable is nonzero.
- R7: The interrupt level has only bit 0, the software source. Writing word 20 with data bit 0 set sets it, writing word 21 with data bit 0 set clears it, and word 20 reads it in bit 0.
- R8: Writing word 26 ORs the data into the fast interrupt enable, and writing word 27 clears the bits set in the data. Word 26 reads the enable, word 24 reads the level ANDed with it, and word 25 reads the raw level. The fiq_o output is high whenever the level ANDed with the fast enable is nonzero.
- R9: A write to word 3 stores the data with bit 3 forced to zero. remap_o follows stored bit 2 (0 means flash at address zero) and led_o follows stored bit 0. A word 3 write with data bit 3 set drives board_rst_o high for exactly the one cycle after the write edge.
- R10: Words 8 and 9 are plain read/write registers.
- R11: A read of an undecoded word returns zero. A write to an undecoded or read-only word changes no register. In either case err_o is high for exactly the one cycle after the access edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle, zero when no read |
| err_o | output | 1 | One-cycle pulse after a bad access |
| remap_o | output | 1 | 1 = RAM at address zero, 0 = flash |
| board_rst_o | output | 1 | One-cycle board reset request |
| led_o | output | 1 | Status LED |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
The bench targets the lock key. It writes keys whose upper half is nonzero, writes near-miss keys, and writes the oscillators both before and after the unlock. A design that compares all 32 bits, or fails to drop a locked write, returns the wrong oscillator value on readback. It checks that set and clear addresses touch only the bits named in the data, so a design that overwrites the flags loses bits it should keep. It checks that board_rst_o and err_o are one-cycle pulses placed right after the access. It checks that read-only words, such as the identity word, reject writes and flag them, which a decoder that shares write and read decoding would miss. Random mixed traffic, with the key written often, keeps irq_o and fiq_o under comparison against a model of the level and enables after every access.

// File: rtl/cm_sysctl.sv
module cm_sysctl #(
  parameter int          ADDR_W    = 7,
  parameter int          MEM_MB    = 128,
  parameter logic [31:0] ID_WORD   = 32'h411A3001,
  parameter logic [31:0] STAT_WORD = 32'h00100000,
  parameter logic [15:0] KEY       = 16'hA05F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              err_o,
  output logic              remap_o,
  output logic              board_rst_o,
  output logic              led_o,
  output logic              irq_o,
  output logic              fiq_o
);

  localparam logic [31:0] SIZE_CODE = (MEM_MB >= 256) ? 32'h10 :
                                      (MEM_MB >= 128) ? 32'h0C :
                                      (MEM_MB >= 64)  ? 32'h08 :
                                      (MEM_MB >= 32)  ? 32'h04 : 32'h0;
  localparam logic [31:0] SDRAM_RST = 32'h00011122 | SIZE_CODE;
  localparam logic [31:0] OSC_RST   = 32'h01000048;
  localparam logic [31:0] AUX_RST   = 32'h0007FEFF;
  localparam logic [31:0] INIT_RST  = 32'h00000112;
  localparam logic [31:0] ZERO_BASE = 32'd64;

  logic [31:0] osc, aux, ctrl, sdram, init_w, flags, nvflags, ien, fen;
  logic [15:0] lock;
  logic        lvl;
  logic [31:0] widx, lvl32, rval;
  logic        rd_ok, wr_ok, unlocked, wr, rd;

  assign widx     = 32'(bus_addr);
  assign lvl32    = {31'd0, lvl};
  assign unlocked = (lock == KEY);
  assign wr       = bus_sel & bus_we;
  assign rd       = bus_sel & ~bus_we;

  always_comb begin
    rd_ok = 1'b1;
    rval  = '0;
    case (widx)
      32'd0:  rval = ID_WORD;
      32'd1:  rval = '0;
      32'd2:  rval = osc;
      32'd3:  rval = ctrl;
      32'd4:  rval = STAT_WORD;
      32'd5:  rval = unlocked ? {15'd0, 1'b1, lock} : {16'd0, lock};
      32'd7:  rval = aux;
      32'd8:  rval = sdram;
      32'd9:  rval = init_w;
      32'd12: rval = flags;
      32'd14: rval = nvflags;
      32'd16: rval = lvl32 & ien;
      32'd17: rval = lvl32;
      32'd18: rval = ien;
      32'd20: rval = lvl32;
      32'd24: rval = lvl32 & fen;
      32'd25: rval = lvl32;
      32'd26: rval = fen;
      32'd32, 32'd33, 32'd34, 32'd35: rval = '0;
      default: rd_ok = (widx >= ZERO_BASE);
    endcase
  end

  always_comb begin
    case (widx)
      32'd2, 32'd3, 32'd5, 32'd7, 32'd8, 32'd9,
      32'd12, 32'd13, 32'd14, 32'd15, 32'd18, 32'd19,
      32'd20, 32'd21, 32'd26, 32'd27,
      32'd32, 32'd33, 32'd34, 32'd35: wr_ok = 1'b1;
      default: wr_ok = 1'b0;
    endcase
  end

  assign bus_rdata = rd ? rval : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      osc <= OSC_RST;  aux <= AUX_RST;  ctrl <= '0;  sdram <= SDRAM_RST;
      init_w <= INIT_RST;  flags <= '0;  nvflags <= '0;  ien <= '0;  fen <= '0;
      lock <= '0;  lvl <= 1'b0;  err_o <= 1'b0;  board_rst_o <= 1'b0;
    end else begin
      err_o       <= bus_sel & (bus_we ? ~wr_ok : ~rd_ok);
      board_rst_o <= wr & (widx == 32'd3) & bus_wdata[3];
      if (wr) begin
        case (widx)
          32'd2:  if (unlocked) osc <= bus_wdata;
          32'd3:  ctrl <= bus_wdata & ~32'h8;
          32'd5:  lock <= bus_wdata[15:0];
          32'd7:  if (unlocked) aux <= bus_wdata;
          32'd8:  sdram <= bus_wdata;
          32'd9:  init_w <= bus_wdata;
          32'd12: flags <= flags | bus_wdata;
          32'd13: flags <= flags & ~bus_wdata;
          32'd14: nvflags <= nvflags | bus_wdata;
          32'd15: nvflags <= nvflags & ~bus_wdata;
          32'd18: ien <= ien | bus_wdata;
          32'd19: ien <= ien & ~bus_wdata;
          32'd20: if (bus_wdata[0]) lvl <= 1'b1;
          32'd21: if (bus_wdata[0]) lvl <= 1'b0;
          32'd26: fen <= fen | bus_wdata;
          32'd27: fen <= fen & ~bus_wdata;
          default: ;
        endcase
      end
    end
  end

  assign remap_o = ctrl[2];
  assign led_o   = ctrl[0];
  assign irq_o   = |(lvl32 & ien);
  assign fiq_o   = |(lvl32 & fen);

  assert_lock_low16_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == 32'd5) |=> (lock == $past(bus_wdata[15:0])));

  assert_osc_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == 32'd2 && !unlocked) |=> $stable(osc));

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == 32'd12) |=> ((flags & $past(bus_wdata)) == $past(bus_wdata)));

  assert_flag_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == 32'd13) |=> ((flags & $past(bus_wdata)) == 32'd0));

  assert_irq_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == 32'd19 && bus_wdata == 32'hFFFFFFFF) |=> !irq_o);

  assert_fiq_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == 32'd21 && bus_wdata[0]) |=> (!fiq_o && !irq_o));

  assert_brst_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == 32'd3 && bus_wdata[3]) |=> board_rst_o);

  assert_brst_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    board_rst_o |-> $past(wr && widx == 32'd3 && bus_wdata[3]));

  assert_err_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(bus_sel));

endmodule

// File: tb/cm_sysctl_test.sv
module cm_sysctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        err_o, remap_o, board_rst_o, led_o, irq_o, fiq_o;

  int total = 0, bad = 0;

  cm_sysctl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .err_o(err_o), .remap_o(remap_o), .board_rst_o(board_rst_o),
    .led_o(led_o), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  always #2.5 clk = ~clk;

  logic [31:0] m_osc, m_aux, m_ctrl, m_sdram, m_init, m_flags, m_nv, m_ien, m_fen;
  logic [15:0] m_lock;
  logic        m_lvl;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit rd_legal(input int a);
    return (a inside {0,1,2,3,4,5,7,8,9,12,14,16,17,18,20,24,25,26,32,33,34,35}) || a >= 64;
  endfunction

  function automatic bit wr_legal(input int a);
    return a inside {2,3,5,7,8,9,12,13,14,15,18,19,20,21,26,27,32,33,34,35};
  endfunction

  function automatic logic [31:0] exp_rd(input int a);
    case (a)
      0: return 32'h411A3001;
      2: return m_osc;
      3: return m_ctrl;
      4: return 32'h00100000;
      5: return (m_lock == 16'hA05F) ? 32'h0001A05F : {16'd0, m_lock};
      7: return m_aux;
      8: return m_sdram;
      9: return m_init;
      12: return m_flags;
      14: return m_nv;
      16: return {31'd0, m_lvl} & m_ien;
      17, 20, 25: return {31'd0, m_lvl};
      18: return m_ien;
      24: return {31'd0, m_lvl} & m_fen;
      26: return m_fen;
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_wr(input int a, input logic [31:0] d);
    case (a)
      2: if (m_lock == 16'hA05F) m_osc = d;
      3: m_ctrl = d & ~32'h8;
      5: m_lock = d[15:0];
      7: if (m_lock == 16'hA05F) m_aux = d;
      8: m_sdram = d;
      9: m_init = d;
      12: m_flags |= d;
      13: m_flags &= ~d;
      14: m_nv |= d;
      15: m_nv &= ~d;
      18: m_ien |= d;
      19: m_ien &= ~d;
      20: if (d[0]) m_lvl = 1'b1;
      21: if (d[0]) m_lvl = 1'b0;
      26: m_fen |= d;
      27: m_fen &= ~d;
      default: ;
    endcase
  endtask

  task automatic check_pins(input string req);
    chk({req, " remap_o"}, {31'd0, remap_o}, {31'd0, m_ctrl[2]});
    chk({req, " led_o"},   {31'd0, led_o},   {31'd0, m_ctrl[0]});
    chk({req, " irq_o"},   {31'd0, irq_o},   {31'd0, |({31'd0, m_lvl} & m_ien)});
    chk({req, " fiq_o"},   {31'd0, fiq_o},   {31'd0, |({31'd0, m_lvl} & m_fen)});
  endtask

  // one access; read data sampled mid-cycle, err/board reset one cycle later
  task automatic acc(input string req, input bit we, input int a, input logic [31:0] d);
    logic [31:0] r;
    bit e_err, e_brst;
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = 7'(a); bus_wdata = d;
    #1 r = bus_rdata;
    if (!we) chk({req, " rdata"}, r, exp_rd(a));
    e_err  = we ? !wr_legal(a) : !rd_legal(a);
    e_brst = we && a == 3 && d[3];
    if (we) model_wr(a, d);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    chk({req, " err_o R11"}, {31'd0, err_o}, {31'd0, e_err});
    chk({req, " board_rst_o R9"}, {31'd0, board_rst_o}, {31'd0, e_brst});
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5071));
    m_osc = 32'h01000048; m_aux = 32'h0007FEFF; m_ctrl = 0; m_sdram = 32'h0001112E;
    m_init = 32'h00000112; m_flags = 0; m_nv = 0; m_ien = 0; m_fen = 0; m_lock = 0; m_lvl = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk("R2 err_o", {31'd0, err_o}, 32'd0);
    check_pins("R2");
    foreach (m_flags[i]) if (i < 1) begin end
    acc("R2 osc", 0, 2, 0);
    acc("R2 aux", 0, 7, 0);
    acc("R2 init", 0, 9, 0);
    acc("R2 sdram", 0, 8, 0);
    acc("R2 ctrl", 0, 3, 0);
    // R1 constants and zero regions
    acc("R1 id", 0, 0, 0);
    acc("R1 stat", 0, 4, 0);
    acc("R1 word1", 0, 1, 0);
    acc("R1 volt wr", 1, 33, 32'hFFFFFFFF);
    acc("R1 volt rd", 0, 33, 0);
    acc("R1 zero region", 0, 100, 0);
    // R4 locked write dropped, R3 near miss
    acc("R4 osc locked", 1, 2, 32'h12345678);
    acc("R4 osc readback", 0, 2, 0);
    acc("R3 near key", 1, 5, 32'h0000A05E);
    acc("R3 near key rd", 0, 5, 0);
    acc("R4 aux near key", 1, 7, 32'hCAFEF00D);
    acc("R4 aux readback", 0, 7, 0);
    acc("R3 key high bits", 1, 5, 32'hFFFFA05F);
    acc("R3 key rd", 0, 5, 0);
    acc("R4 osc unlocked", 1, 2, 32'h12345678);
    acc("R4 osc readback2", 0, 2, 0);
    acc("R4 aux unlocked", 1, 7, 32'h00ABCDEF);
    acc("R4 aux readback2", 0, 7, 0);
    // R5 flags
    acc("R5 set", 1, 12, 32'h0000F0F0);
    acc("R5 set2", 1, 12, 32'h0F000000);
    acc("R5 clr", 1, 13, 32'h00003030);
    acc("R5 rd", 0, 12, 0);
    acc("R5 nv set", 1, 14, 32'h80000001);
    acc("R5 nv clr", 1, 15, 32'h00000001);
    acc("R5 nv rd", 0, 14, 0);
    // R7, R6, R8 interrupts
    acc("R7 soft set", 1, 20, 32'h1);
    acc("R7 soft rd", 0, 20, 0);
    acc("R6 raw", 0, 17, 0);
    acc("R6 masked none", 0, 16, 0);
    check_pins("R6 no enable");
    acc("R6 en set", 1, 18, 32'h00000003);
    acc("R6 masked", 0, 16, 0);
    check_pins("R6 enabled");
    acc("R8 fen set", 1, 26, 32'h1);
    acc("R8 masked", 0, 24, 0);
    acc("R8 raw", 0, 25, 0);
    check_pins("R8 enabled");
    acc("R6 en clr", 1, 19, 32'h1);
    acc("R6 en rd", 0, 18, 0);
    check_pins("R6 cleared");
    acc("R7 soft clr bit1 only", 1, 21, 32'h2);
    check_pins("R7 no clear");
    acc("R7 soft clr", 1, 21, 32'h1);
    check_pins("R7 cleared");
    // R9 control
    acc("R9 remap led", 1, 3, 32'h0000000D);
    acc("R9 ctrl rd", 0, 3, 0);
    check_pins("R9 set");
    acc("R9 pulse ends", 0, 3, 0);
    acc("R9 clear", 1, 3, 32'h0);
    check_pins("R9 cleared");
    // R10
    acc("R10 sdram wr", 1, 8, 32'h5A5A0001);
    acc("R10 sdram rd", 0, 8, 0);
    acc("R10 init wr", 1, 9, 32'h00000777);
    acc("R10 init rd", 0, 9, 0);
    // R11
    acc("R11 rd timer", 0, 6, 0);
    acc("R11 rd clr addr", 0, 13, 0);
    acc("R11 wr id", 1, 0, 32'hDEADBEEF);
    acc("R11 id kept", 0, 0, 0);
    acc("R11 wr raw", 1, 17, 32'hFFFFFFFF);
    acc("R11 wr zero region", 1, 90, 32'h1);
    acc("R11 wr hole", 1, 40, 32'h1);
    // random mix
    for (int n = 0; n < 600; n++) begin
      int a;
      logic [31:0] d;
      bit we;
      a  = ($urandom % 2) ? int'($urandom % 36) : int'($urandom % 128);
      d  = $urandom;
      we = $urandom % 2;
      if (a == 5 && ($urandom % 2)) d[15:0] = 16'hA05F;
      acc("RND R3 R4 R5 R6 R7 R8 R10", we, a, d);
      check_pins("RND R6 R8 R9");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule